// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This unit decides, every cycle, where a five-stage integer pipeline takes its operands from. For each of the two ALU operands of the instruction now in execute, it chooses among three sources. The first is the register file. The second is the result held in the execute/memory register. The third is the result held in the memory/writeback register. When both later stages write the wanted register, the younger value wins. A separate select steers a loaded value from the writeback register straight into the data-memory write port, for a store that sits in the memory stage. Register zero never takes part in any of these matches. The register file is taken to write before it reads within a cycle, so a writer three instructions ahead needs no bypass.

An ALU result is ready for the next instruction, but a load result is not. When a load in execute writes a register that the decoding instruction reads as an ALU source, the unit raises `hold`. This freezes the program counter and the fetch/decode register, and puts a bubble into the decode/execute register. The address operand of a store counts as such a source. The data operand of a store does not: that value is bypassed later, in the memory stage. Ordering hazards between two writes, or between a write and an earlier read, cannot arise, because every read is early and every write is late.

A two-state machine keeps the interlock to exactly one cycle. In state `ILK_FLOW`, `hold` follows the load-use detector. The transition `FLOW_TO_BUBBLE` is taken when `hold` is raised. State `ILK_BUBBLE` covers the cycle in which the bubble is in execute. There `hold` is forced low, and the transition `BUBBLE_TO_FLOW` is always taken on the next edge. Asynchronous reset enters `ILK_FLOW`. All selects are combinational from the inputs.

Top module: `fwd_interlock_unit`

## Requirements
- R1: Reset places the interlock in the free-flowing state. Once out of reset, all outputs are 0 when no stage writes a register. A reset applied during the bubble cycle makes `hold` follow the detector again at once.
- R2: `fwd_a` is 2'b10 when `mem_we` is 1 and `mem_rd` equals `ex_rs1`. Otherwise it is 2'b01 when `wb_we` is 1 and `wb_rd` equals `ex_rs1`. Otherwise it is 2'b00, meaning the register file. It is never 2'b11.
- R3: `fwd_b` follows the same encoding and rules as R2, with `ex_rs2` as the source.
- R4: When both the memory-stage writer and the writeback-stage writer match a source, the select is 2'b10, the younger value.
- R5: A register number of 0 never causes a bypass select other than 2'b00. It never raises `fwd_sd` and never raises `hold`.
- R6: A stage whose write enable is 0 is ignored for bypassing, even when its destination matches.
- R7: `hold` is 1 in the free-flowing state under three conditions: `ex_is_load` is 1, `ex_rd` is nonzero, and `ex_rd` equals `id_rs1`, or equals `id_rs2` when `id_is_store` is 0.
- R8: A decoding store whose data register (`id_rs2`) is the load destination, and whose address register (`id_rs1`) is not, does not raise `hold`.
- R9: `fwd_sd` is 1 exactly when `mem_is_store` is 1, `wb_we` is 1, and `wb_rd` is nonzero and equal to `mem_sd_rs`.
- R10: In the cycle after `hold` was 1, `hold` is 0 whatever the inputs. In the cycle after that, `hold` again follows R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs1 | input | REG_W | First source register of the decoding instruction (store address) |
| id_rs2 | input | REG_W | Second source register of the decoding instruction (store data if a store) |
| id_is_store | input | 1 | Decoding instruction is a store |
| ex_rs1 | input | REG_W | First source register of the instruction in execute |
| ex_rs2 | input | REG_W | Second source register of the instruction in execute |
| ex_rd | input | REG_W | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_W | Destination register held in the execute/memory register |
| mem_we | input | 1 | Execute/memory instruction writes a register |
| mem_is_store | input | 1 | Instruction in memory stage is a store |
| mem_sd_rs | input | REG_W | Store-data register of the instruction in memory stage |
| wb_rd | input | REG_W | Destination register held in the memory/writeback register |
| wb_we | input | 1 | Memory/writeback instruction writes a register |
| fwd_a | output | 2 | Select for ALU operand A: 00 file, 01 writeback, 10 memory stage |
| fwd_b | output | 2 | Select for ALU operand B, same encoding |
| fwd_sd | output | 1 | Take store data from the memory/writeback result |
| hold | output | 1 | Freeze PC and fetch/decode, zero decode/execute |

## Verification
The two operand selects, the store-data select, and `hold` in the free-flowing state are combinational. They are due in the same cycle as the inputs that cause them. The bench drives on the falling edge and samples one nanosecond later, with no edge in between. The suppression of `hold` is due only after the rising edge that records the bubble. So each interlock case is checked three times, on three consecutive falling edges with the inputs held: 1, then 0, then 1 again. The inputs are then cleared for one cycle so that the state machine has returned before the next case. A reduced register width of 2 lets the bench sweep every combination of the relevant inputs.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_MEMWB = 2'b01,
        FWD_EXMEM = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        ILK_FLOW   = 1'b0,
        ILK_BUBBLE = 1'b1
    } ilk_state_e;

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             exmem_we,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             memwb_we,
    input  logic [REG_W-1:0] memwb_rd,
    output fwd_sel_e         sel
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic hit_exmem;
    logic hit_memwb;

    always_comb begin
        hit_exmem = exmem_we && (exmem_rd != ZERO_REG) && (exmem_rd == src);
        hit_memwb = memwb_we && (memwb_rd != ZERO_REG) && (memwb_rd == src);
        if (hit_exmem) begin
            sel = FWD_EXMEM;
        end else if (hit_memwb) begin
            sel = FWD_MEMWB;
        end else begin
            sel = FWD_RF;
        end
    end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
    parameter int REG_W = 5
) (
    input  logic             mem_is_store,
    input  logic [REG_W-1:0] mem_sd_rs,
    input  logic             wb_we,
    input  logic [REG_W-1:0] wb_rd,
    output logic             sd_bypass
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        sd_bypass = mem_is_store && wb_we && (wb_rd != ZERO_REG) && (wb_rd == mem_sd_rs);
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_is_store,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_is_load,
    output logic             hazard
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic addr_dep;
    logic alu_b_dep;

    always_comb begin
        addr_dep  = (id_rs1 == ex_rd);
        alu_b_dep = !id_is_store && (id_rs2 == ex_rd);
        hazard    = ex_is_load && (ex_rd != ZERO_REG) && (addr_dep || alu_b_dep);
    end
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_is_store,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic             mem_is_store,
    input  logic [REG_W-1:0] mem_sd_rs,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             fwd_sd,
    output logic             hold
);
    localparam int NUM_OPS = 2;

    logic [REG_W-1:0] op_src [NUM_OPS];
    fwd_sel_e         op_sel [NUM_OPS];

    assign op_src[0] = ex_rs1;
    assign op_src[1] = ex_rs2;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_operand_sel #(.REG_W(REG_W)) u_sel (
            .src      (op_src[g]),
            .exmem_we (mem_we),
            .exmem_rd (mem_rd),
            .memwb_we (wb_we),
            .memwb_rd (wb_rd),
            .sel      (op_sel[g])
        );
    end

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

    fwd_store_sel #(.REG_W(REG_W)) u_sd (
        .mem_is_store (mem_is_store),
        .mem_sd_rs    (mem_sd_rs),
        .wb_we        (wb_we),
        .wb_rd        (wb_rd),
        .sd_bypass    (fwd_sd)
    );

    logic hazard;

    load_use_detect #(.REG_W(REG_W)) u_lud (
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .id_is_store (id_is_store),
        .ex_rd       (ex_rd),
        .ex_is_load  (ex_is_load),
        .hazard      (hazard)
    );

    ilk_state_e state_q;
    ilk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ILK_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        hold    = 1'b0;
        unique case (state_q)
            ILK_FLOW: begin
                hold = hazard;
                if (hazard) begin
                    state_d = ILK_BUBBLE;
                end
            end
            ILK_BUBBLE: begin
                state_d = ILK_FLOW;
            end
        endcase
    end
endmodule

// File: rtl/fwd_interlock_checker.sv
module fwd_interlock_checker #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] id_rs1,
    input logic             id_is_store,
    input logic [REG_W-1:0] ex_rs1,
    input logic [REG_W-1:0] ex_rs2,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_is_load,
    input logic [REG_W-1:0] mem_rd,
    input logic             mem_we,
    input logic             mem_is_store,
    input logic [REG_W-1:0] wb_rd,
    input logic             wb_we,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b,
    input logic             fwd_sd,
    input logic             hold
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    AST_A_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_a != 2'b11); // R2
    AST_B_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_b != 2'b11); // R3
    AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wb_we && mem_rd == wb_rd && mem_rd == ex_rs1 && ex_rs1 != ZERO_REG)
        |-> fwd_a == 2'b10); // R4
    AST_ZERO_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs2 == ZERO_REG) |-> fwd_b == 2'b00); // R5
    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we && !wb_we) |-> (fwd_a == 2'b00 && fwd_b == 2'b00 && !fwd_sd)); // R6
    AST_HOLD_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (ex_is_load && ex_rd != ZERO_REG)); // R7
    AST_STORE_DATA_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_store && id_rs1 != ex_rd) |-> !hold); // R8
    AST_SD_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_is_store |-> !fwd_sd); // R9
    AST_NO_DOUBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !hold); // R10
endmodule

bind fwd_interlock_unit fwd_interlock_checker #(.REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_rs1       (id_rs1),
    .id_is_store  (id_is_store),
    .ex_rs1       (ex_rs1),
    .ex_rs2       (ex_rs2),
    .ex_rd        (ex_rd),
    .ex_is_load   (ex_is_load),
    .mem_rd       (mem_rd),
    .mem_we       (mem_we),
    .mem_is_store (mem_is_store),
    .wb_rd        (wb_rd),
    .wb_we        (wb_we),
    .fwd_a        (fwd_a),
    .fwd_b        (fwd_b),
    .fwd_sd       (fwd_sd),
    .hold         (hold)
);

// File: tb/test_fwd_interlock_unit.sv
`timescale 1ns/1ps
module test_fwd_interlock_unit;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] id_rs1 = '0, id_rs2 = '0;
    logic          id_is_store = 1'b0;
    logic [RW-1:0] ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic          ex_is_load = 1'b0;
    logic [RW-1:0] mem_rd = '0;
    logic          mem_we = 1'b0, mem_is_store = 1'b0;
    logic [RW-1:0] mem_sd_rs = '0, wb_rd = '0;
    logic          wb_we = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          fwd_sd, hold;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    fwd_interlock_unit #(.REG_W(RW)) i_fwd_interlock_unit (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_store(id_is_store),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_is_store(mem_is_store),
        .mem_sd_rs(mem_sd_rs), .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_sd(fwd_sd), .hold(hold)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(logic [RW-1:0] s, logic ew, logic [RW-1:0] erd,
                                           logic ww, logic [RW-1:0] wrd);
        if (ew && erd != 0 && erd == s) return 2'b10;
        if (ww && wrd != 0 && wrd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(string base, logic [RW-1:0] s, logic ew, logic [RW-1:0] erd,
                                      logic ww, logic [RW-1:0] wrd);
        if (s == 0) return "R5";
        if (ew && ww && erd == s && wrd == s) return "R4";
        if ((!ew && erd == s) || (!ww && wrd == s)) return "R6";
        return base;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk("R1 fwd_a", fwd_a, 2'b00);
        chk("R1 fwd_b", fwd_b, 2'b00);
        chk("R1 fwd_sd", {1'b0, fwd_sd}, 2'b00);
        chk("R1 hold", {1'b0, hold}, 2'b00);

        // R1: reset during bubble restores flow
        @(negedge clk);
        ex_is_load = 1'b1; ex_rd = 2'd1; id_rs1 = 2'd1;
        #1 chk("R7 pre-reset hold", {1'b0, hold}, 2'b01);
        @(negedge clk);
        #1 chk("R10 bubble hold", {1'b0, hold}, 2'b00);
        rst_n = 1'b0;
        #1 chk("R1 reset in bubble", {1'b0, hold}, 2'b01);
        @(negedge clk) ex_is_load = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6: operand select sweep
        for (int i = 0; i < 256; i++) begin
            logic [RW-1:0] s1, s2, erd, wrd;
            logic ew, ww;
            s1 = i[1:0]; erd = i[3:2]; ew = i[4]; wrd = i[6:5]; ww = i[7];
            s2 = ~s1;
            @(negedge clk);
            ex_rs1 = s1; ex_rs2 = s2; mem_rd = erd; mem_we = ew; wb_rd = wrd; wb_we = ww;
            #1;
            chk(sel_tag("R2", s1, ew, erd, ww, wrd), fwd_a, exp_sel(s1, ew, erd, ww, wrd));
            chk(sel_tag("R3", s2, ew, erd, ww, wrd), fwd_b, exp_sel(s2, ew, erd, ww, wrd));
        end
        @(negedge clk);
        mem_we = 1'b0; wb_we = 1'b0;

        // R9 R5: store-data select sweep
        for (int k = 0; k < 64; k++) begin
            logic ms, ww;
            logic [RW-1:0] srs, wrd;
            logic e;
            ms = k[0]; srs = k[2:1]; ww = k[3]; wrd = k[5:4];
            e = ms && ww && wrd != 0 && wrd == srs;
            @(negedge clk);
            mem_is_store = ms; mem_sd_rs = srs; wb_we = ww; wb_rd = wrd;
            #1 chk((wrd == 0) ? "R5 fwd_sd" : "R9 fwd_sd", {1'b0, fwd_sd}, {1'b0, e});
        end
        @(negedge clk);
        mem_is_store = 1'b0; wb_we = 1'b0;

        // R7 R8 R5 R10: load-use sweep
        for (int j = 0; j < 256; j++) begin
            logic ld, st, e;
            logic [RW-1:0] erd, r1, r2;
            string tag;
            ld = j[0]; erd = j[2:1]; r1 = j[4:3]; r2 = j[6:5]; st = j[7];
            e = ld && erd != 0 && (r1 == erd || (!st && r2 == erd));
            if (erd == 0) tag = "R5 hold";
            else if (st && r2 == erd && r1 != erd) tag = "R8 hold";
            else tag = "R7 hold";
            @(negedge clk);
            ex_is_load = ld; ex_rd = erd; id_rs1 = r1; id_rs2 = r2; id_is_store = st;
            #1 chk(tag, {1'b0, hold}, {1'b0, e});
            if (e) begin
                @(negedge clk);
                #1 chk("R10 second cycle", {1'b0, hold}, 2'b00);
                @(negedge clk);
                #1 chk("R10 third cycle", {1'b0, hold}, 2'b01);
                @(negedge clk);
                ex_is_load = 1'b0;
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule